// File: doc/BRIEF.md
# Interrupt Vector Fetch Controller

This controller sits between the interrupt sources of a processor core and its byte-wide read path. It watches three sources: a level-sensitive maskable request gated by an internal enable bit, a nonmaskable input that reacts to rising edges, and a software request that carries its own 8-bit type number. It picks one source, finds out the type number, reads the four-byte table entry for that type from the vector table at the bottom of the address space, and delivers the handler's segment and offset with a one-cycle completion pulse.

For a maskable request, the type number comes from an external acknowledge handshake. The active-low acknowledge strobe is driven low twice. The interrupting device places the type number on `ack_type` during the second low pulse. For nonmaskable and software requests there is no handshake, and fetching begins at once.

The state machine has six states:

- `ST_IDLE` waits for a request. It moves to `ST_ACK1` for a maskable request, or to `ST_FETCH` for the other two sources.
- `ST_ACK1` holds the first low pulse, then moves to `ST_GAP`.
- `ST_GAP` holds the high interval, then moves to `ST_ACK2`.
- `ST_ACK2` holds the second low pulse and captures the type, then moves to `ST_FETCH`.
- `ST_FETCH` issues four reads and moves to `ST_DONE` once the fourth byte is accepted.
- `ST_DONE` raises the completion pulse and returns to `ST_IDLE`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A maskable request (`irq_req` high) is accepted only while `int_en` is 1. With `int_en` at 0, `ack_n` stays high and no read is issued.
- R2: An accepted maskable request drives `ack_n` low for exactly two low pulses. Each pulse lasts 2 clocks, and the pulses are separated by 2 clocks of high.
- R3: The type number is taken from `ack_type` only in the last clock of the second low pulse. Values on `ack_type` at any other time have no effect on the fetched vector.
- R4: A vector fetch issues four reads at addresses type*4+0, +1, +2, +3, in that order. `rd_req` stays high with `rd_addr` unchanged until `rd_valid` is seen.
- R5: Vector bytes are assembled as follows. Byte 0 is the offset low byte, byte 1 the offset high byte, byte 2 the segment low byte and byte 3 the segment high byte. `done` is high for one clock, and `hnd_off`/`hnd_seg` are valid from that clock and hold until the next fetch writes them.
- R6: A rising edge on `nmi_in` is serviced with type 2 (reads at 0x08 to 0x0B) whatever the value of `int_en`, with no acknowledge pulses. Holding the input high yields one service only. An edge that arrives while the controller is busy is kept and serviced afterwards.
- R7: A one-clock `swi_req` pulse in `ST_IDLE` is serviced with type `swi_type`, whatever the value of `int_en`, with no acknowledge pulses. A `swi_req` pulse while the controller is busy is ignored.
- R8: When sources compete in the same idle cycle, the nonmaskable edge wins over the software request, which wins over the maskable request. A software request that loses is dropped.
- R9: A pulse on `ie_set` sets `int_en`. `int_en` returns to 0 in the clock after `done`, and this clear takes precedence over a simultaneous `ie_set`.
- R10: During and right after reset, `ack_n`=1, `rd_req`=0, `done`=0, `int_en`=0, and `hnd_off`=`hnd_seg`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 1 | Maskable request, level sensitive |
| nmi_in | input | 1 | Nonmaskable request, rising-edge sensitive |
| ie_set | input | 1 | One-clock pulse that sets the enable bit |
| swi_req | input | 1 | Software interrupt request pulse |
| swi_type | input | 8 | Type number of the software request |
| ack_type | input | 8 | Type number driven by the device during acknowledge |
| rd_valid | input | 1 | Read data on `rd_data` is valid this clock |
| rd_data | input | 8 | Byte returned for the current read |
| ack_n | output | 1 | Active-low acknowledge strobe |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | ADDR_W | Byte address of the current read |
| hnd_off | output | 16 | Handler offset |
| hnd_seg | output | 16 | Handler segment |
| done | output | 1 | One-clock pulse: handler address is ready |
| int_en | output | 1 | Current value of the enable bit |

## Verification
The assertions assume that `rd_valid` is raised only while `rd_req` is high, for one clock per byte. They also assume that `ie_set` never coincides with a clock in which the enable bit must already hold, which the stimulus respects by pulsing it only between services. The stimulus uses `swi_req` only as a one-clock pulse and drives `ack_type` with junk everywhere except the capture clock. It returns read data after a random wait of zero to two clocks, so that the address-hold rule is exercised under stalls.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK1,
        ST_GAP,
        ST_ACK2,
        ST_FETCH,
        ST_DONE
    } irqv_state_e;

    localparam int unsigned TYPE_W    = 8;
    localparam int unsigned VEC_BYTES = 4;
    localparam logic [TYPE_W-1:0] NMI_TYPE = 8'd2;

endpackage

// File: rtl/irqv_arb.sv
module irqv_arb
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_in,
    input  logic              irq_req,
    input  logic              int_en,
    input  logic              swi_req,
    input  logic [TYPE_W-1:0] swi_type,
    input  logic              take,
    output logic              req_any,
    output logic              is_ext,
    output logic [TYPE_W-1:0] pick_type
);
    logic nmi_prev;
    logic nmi_pend;
    logic nmi_rise;
    logic nmi_sel;

    assign nmi_rise = nmi_in & ~nmi_prev;
    assign nmi_sel  = nmi_rise | nmi_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_prev <= nmi_in;
            nmi_pend <= nmi_sel & ~take;
        end
    end

    always_comb begin
        req_any   = 1'b0;
        is_ext    = 1'b0;
        pick_type = '0;
        if (nmi_sel) begin
            req_any   = 1'b1;
            pick_type = NMI_TYPE;
        end else if (swi_req) begin
            req_any   = 1'b1;
            pick_type = swi_type;
        end else if (irq_req && int_en) begin
            req_any = 1'b1;
            is_ext  = 1'b1;
        end
    end

endmodule

// File: rtl/irqv_vecfetch.sv
module irqv_vecfetch
    import irqv_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         accept,
    input  logic [7:0]                   byte_in,
    output logic [$clog2(VEC_BYTES)-1:0] idx,
    output logic                         last,
    output logic [15:0]                  off,
    output logic [15:0]                  seg
);
    localparam int unsigned IDX_W = $clog2(VEC_BYTES);

    logic [8*VEC_BYTES-1:0] vec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            vec_q <= '0;
        end else if (start) begin
            idx <= '0;
        end else if (accept) begin
            vec_q[8*idx +: 8] <= byte_in;
            idx               <= idx + IDX_W'(1);
        end
    end

    assign last = (idx == IDX_W'(VEC_BYTES - 1));
    assign off  = vec_q[15:0];
    assign seg  = vec_q[31:16];

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned PULSE_CLKS = 2,
    parameter int unsigned GAP_CLKS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              nmi_in,
    input  logic              ie_set,
    input  logic              swi_req,
    input  logic [7:0]        swi_type,
    input  logic [7:0]        ack_type,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    output logic              ack_n,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       hnd_off,
    output logic [15:0]       hnd_seg,
    output logic              done,
    output logic              int_en
);
    localparam int unsigned IDX_W  = $clog2(VEC_BYTES);
    localparam int unsigned MAXCNT = (PULSE_CLKS > GAP_CLKS) ? PULSE_CLKS : GAP_CLKS;
    localparam int unsigned CNT_W  = $clog2(MAXCNT + 1);
    localparam int unsigned PAD_W  = ADDR_W - TYPE_W - IDX_W;

    irqv_state_e       st_q, st_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [TYPE_W-1:0] type_q;
    logic              take;
    logic              req_any;
    logic              is_ext;
    logic [TYPE_W-1:0] pick_type;
    logic              cap_type;
    logic              accept;
    logic              last;
    logic [IDX_W-1:0]  idx;

    irqv_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_in    (nmi_in),
        .irq_req   (irq_req),
        .int_en    (int_en),
        .swi_req   (swi_req),
        .swi_type  (swi_type),
        .take      (take),
        .req_any   (req_any),
        .is_ext    (is_ext),
        .pick_type (pick_type)
    );

    irqv_vecfetch u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (take),
        .accept  (accept),
        .byte_in (rd_data),
        .idx     (idx),
        .last    (last),
        .off     (hnd_off),
        .seg     (hnd_seg)
    );

    // Next-state logic
    always_comb begin
        st_n     = st_q;
        cnt_n    = cnt_q;
        take     = 1'b0;
        cap_type = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_any) begin
                    take  = 1'b1;
                    cnt_n = '0;
                    st_n  = is_ext ? ST_ACK1 : ST_FETCH;
                end
            end
            ST_ACK1: begin
                if (cnt_q == CNT_W'(PULSE_CLKS - 1)) begin
                    cnt_n = '0;
                    st_n  = ST_GAP;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            ST_GAP: begin
                if (cnt_q == CNT_W'(GAP_CLKS - 1)) begin
                    cnt_n = '0;
                    st_n  = ST_ACK2;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            ST_ACK2: begin
                if (cnt_q == CNT_W'(PULSE_CLKS - 1)) begin
                    cnt_n    = '0;
                    cap_type = 1'b1;
                    st_n     = ST_FETCH;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            ST_FETCH: begin
                if (rd_valid && last) begin
                    st_n = ST_DONE;
                end
            end
            ST_DONE: begin
                st_n = ST_IDLE;
            end
            default: begin
                st_n = ST_IDLE;
            end
        endcase
    end

    // State register, type register and enable bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            type_q <= '0;
            int_en <= 1'b0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            if (take && !is_ext) begin
                type_q <= pick_type;
            end else if (cap_type) begin
                type_q <= ack_type;
            end
            if (st_q == ST_DONE) begin
                int_en <= 1'b0;
            end else if (ie_set) begin
                int_en <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        ack_n   = !((st_q == ST_ACK1) || (st_q == ST_ACK2));
        rd_req  = (st_q == ST_FETCH);
        done    = (st_q == ST_DONE);
        rd_addr = {{PAD_W{1'b0}}, type_q, idx};
    end

    assign accept = rd_req & rd_valid;

endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
    parameter int unsigned ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_n,
    input logic              rd_req,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              done,
    input logic              int_en
);
    // R1: acknowledge only runs while the enable bit is set
    a_r1_ack_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> int_en);

    // R2: each low pulse is exactly two clocks wide
    a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |=> !ack_n ##1 ack_n);

    // R2: no read overlaps an acknowledge pulse
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ack_n);

    // R4: address held while the read is stalled
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    // R4: consecutive reads step the address by one
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_valid) |=> (done || (rd_req && rd_addr == $past(rd_addr) + ADDR_W'(1))));

    // R5: completion is a single-clock pulse
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: enable bit cleared right after completion
    a_r9_en_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !int_en);

endmodule

bind irq_vector_ctrl irqv_checker #(.ADDR_W(ADDR_W)) u_irqv_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_n    (ack_n),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .done     (done),
    .int_en   (int_en)
);

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
    localparam int ADDR_W = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_req = 1'b0, nmi_in = 1'b0, ie_set = 1'b0, swi_req = 1'b0;
    logic [7:0] swi_type = '0, ack_type = '0, rd_data = '0;
    logic rd_valid = 1'b0;
    logic ack_n, rd_req, done, int_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [15:0] hnd_off, hnd_seg;

    always #5 clk = ~clk;

    irq_vector_ctrl #(.ADDR_W(ADDR_W)) i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_in(nmi_in),
        .ie_set(ie_set), .swi_req(swi_req), .swi_type(swi_type),
        .ack_type(ack_type), .rd_valid(rd_valid), .rd_data(rd_data),
        .ack_n(ack_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .hnd_off(hnd_off), .hnd_seg(hnd_seg), .done(done), .int_en(int_en)
    );

    int n_chk = 0, n_bad = 0;
    int ext_type = 0, cur_type = 0;
    int ack_falls = 0, rdreq_cycles = 0, done_total = 0;
    int p_idx = 0, lowc = 0, highc = 0, w1 = 0, w2 = 0, gapc = 0;
    int rep_pulses = 0, rep_w1 = 0, rep_w2 = 0, rep_gap = 0, rep_nbytes = 0;
    int rep_off = 0, rep_seg = 0, kbyte = 0;
    logic prev_ack = 1'b1;

    function automatic logic [7:0] vbyte(input int a);
        return 8'((a * 73 + 19) ^ (a >> 2));
    endfunction
    function automatic int exp_off(input int t);
        return {vbyte(4 * t + 1), vbyte(4 * t)};
    endfunction
    function automatic int exp_seg(input int t);
        return {vbyte(4 * t + 3), vbyte(4 * t + 2)};
    endfunction

    task automatic chk(input string r, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    // Acknowledge monitor and type driver
    always @(negedge clk) begin
        if (!ack_n) begin
            if (prev_ack) begin
                p_idx++;
                lowc = 0;
                ack_falls++;
                if (p_idx == 2) gapc = highc;
            end
            lowc++;
            if (p_idx == 1) w1 = lowc;
            else if (p_idx == 2) w2 = lowc;
        end else begin
            if (!prev_ack) highc = 0;
            highc++;
        end
        prev_ack = ack_n;
        ack_type = (!ack_n && p_idx == 2 && lowc == 2) ? 8'(ext_type) : 8'($urandom);
        if (rd_req) rdreq_cycles++;
        if (done) begin
            done_total++;
            rep_pulses = p_idx; rep_w1 = w1; rep_w2 = w2; rep_gap = gapc;
            rep_off = int'(hnd_off); rep_seg = int'(hnd_seg);
            p_idx = 0; w1 = 0; w2 = 0; gapc = 0;
        end
    end

    // Read responder with random stalls; R4 address order checked here
    always begin
        @(negedge clk);
        if (rd_req) begin
            repeat (int'($urandom % 3)) @(negedge clk);
            chk("R4 read address", int'(rd_addr), cur_type * 4 + kbyte);
            rd_data  = vbyte(int'(rd_addr));
            rd_valid = 1'b1;
            kbyte++;
            @(negedge clk);
            rd_valid = 1'b0;
        end
        if (done) begin
            rep_nbytes = kbyte;
            kbyte = 0;
        end
    end

    task automatic wait_done();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) begin
                @(negedge clk);
                return;
            end
        end
        chk("watchdog no done", 0, 1);
    endtask

    task automatic check_result(input string r, input int t, input int pulses);
        chk({r, " offset"}, rep_off, exp_off(t));
        chk({r, " segment"}, rep_seg, exp_seg(t));
        chk({r, " R4 byte count"}, rep_nbytes, 4);
        chk({r, " ack pulses"}, rep_pulses, pulses);
        if (pulses == 2) begin
            chk("R2 first pulse width", rep_w1, 2);
            chk("R2 second pulse width", rep_w2, 2);
            chk("R2 gap width", rep_gap, 2);
        end
    endtask

    task automatic pulse_ie();
        ie_set = 1'b1;
        @(negedge clk);
        ie_set = 1'b0;
    endtask

    task automatic run_ext(input int t);
        pulse_ie();
        chk("R9 enable set", int'(int_en), 1);
        ext_type = t; cur_type = t;
        irq_req = 1'b1;
        wait_done();
        irq_req = 1'b0;
        check_result("R3 R5 maskable", t, 2);
        chk("R9 enable cleared", int'(int_en), 0);
    endtask

    task automatic run_nmi();
        cur_type = 2;
        nmi_in = 1'b1;
        @(negedge clk);
        nmi_in = 1'b0;
        wait_done();
        check_result("R6 nmi", 2, 0);
    endtask

    task automatic run_swi(input int t);
        cur_type = t;
        swi_type = 8'(t);
        swi_req = 1'b1;
        @(negedge clk);
        swi_req = 1'b0;
        wait_done();
        check_result("R7 software", t, 0);
    endtask

    initial begin
        #1_500_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int a0, r0, d0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 ack_n", int'(ack_n), 1);
        chk("R10 rd_req", int'(rd_req), 0);
        chk("R10 done", int'(done), 0);
        chk("R10 int_en", int'(int_en), 0);
        chk("R10 offset", int'(hnd_off), 0);
        chk("R10 segment", int'(hnd_seg), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 int_en after release", int'(int_en), 0);

        // R1: masked request produces nothing
        a0 = ack_falls; r0 = rdreq_cycles;
        irq_req = 1'b1;
        repeat (20) @(negedge clk);
        irq_req = 1'b0;
        chk("R1 no ack while disabled", ack_falls - a0, 0);
        chk("R1 no read while disabled", rdreq_cycles - r0, 0);

        run_ext(8'h03);
        run_ext(8'h00);
        run_ext(8'hFF);

        // R9: enable cleared, request held gives no new service
        a0 = ack_falls;
        irq_req = 1'b1;
        repeat (20) @(negedge clk);
        irq_req = 1'b0;
        chk("R9 no reentry after clear", ack_falls - a0, 0);

        // R6: held NMI gives one service, enable still 0
        d0 = done_total; cur_type = 2;
        nmi_in = 1'b1;
        repeat (40) @(negedge clk);
        nmi_in = 1'b0;
        chk("R6 single service when held", done_total - d0, 1);
        check_result("R6 nmi held", 2, 0);

        run_swi(8'hA5);

        // R8: NMI beats maskable in the same cycle
        pulse_ie();
        ext_type = 8'h41; cur_type = 2;
        nmi_in = 1'b1; irq_req = 1'b1;
        wait_done();
        nmi_in = 1'b0; irq_req = 1'b0;
        check_result("R8 nmi over maskable", 2, 0);

        // R8: software beats maskable
        pulse_ie();
        cur_type = 8'h80; swi_type = 8'h80;
        swi_req = 1'b1; irq_req = 1'b1;
        @(negedge clk);
        swi_req = 1'b0;
        wait_done();
        irq_req = 1'b0;
        check_result("R8 software over maskable", 8'h80, 0);

        // R6/R7: NMI edge while busy kept, software pulse while busy dropped
        pulse_ie();
        ext_type = 8'h55; cur_type = 8'h55;
        irq_req = 1'b1;
        for (int i = 0; i < 50 && !rd_req; i++) @(negedge clk);
        nmi_in = 1'b1; swi_type = 8'h77; swi_req = 1'b1;
        @(negedge clk);
        swi_req = 1'b0; nmi_in = 1'b0;
        wait_done();
        irq_req = 1'b0;
        check_result("R3 R5 maskable busy", 8'h55, 2);
        cur_type = 2;
        wait_done();
        check_result("R6 pending nmi", 2, 0);
        d0 = done_total;
        repeat (30) @(negedge clk);
        chk("R7 busy software ignored", done_total - d0, 0);

        // Random mix
        for (int n = 0; n < 40; n++) begin
            int kind;
            kind = int'($urandom % 3);
            if (kind == 0) run_ext(int'($urandom % 256));
            else if (kind == 1) run_nmi();
            else run_swi(int'($urandom % 256));
            repeat (int'($urandom % 4)) @(negedge clk);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule